// File: doc/BRIEF.md
# Framed Byte-Stream Link Receiver

This block turns a framed stream of link bytes, one byte per clock, back into 104-bit parallel transaction words. A rise of the frame input opens a transaction. The first six bytes are a header: a read flag, a burst flag, control bits, a 32-bit destination address, the data size and the write bit. The eight bytes after them carry the low data word and then either the source address or the high data word. When the fourteenth byte arrives, the assembled word is presented for one cycle on one of three outputs. The output is chosen by the transaction kind: write, read request or read response.

If frame stays high after a completed transaction and the burst flag was set, the stream goes on with eight more payload bytes. These bytes make a new transaction. It reuses the previous header, and its destination address is 8 higher. If the burst flag was clear, the extra bytes are discarded. If frame drops partway through a transaction, the partial transaction is thrown away and a sticky error flag is raised.

Two wait outputs go back to the remote transmitter. Each one follows an almost-full indication from the downstream queue it protects. The queue asserts almost-full while it still has room for one more transaction, so the receiver can finish the transaction already in flight.

Top module: `link_rx`

## Requirements
- R1: A rising frame, sampled on a clock edge, starts a transaction, and the byte sampled on that same edge is byte 0. Bit 7 of byte 0 is the read flag and bit 2 is the burst flag.
- R2: The header fields are decoded as follows. Byte 1 gives ctrl[3:0] in bits 7:4 and dstaddr[31:28] in bits 3:0. Bytes 2, 3 and 4 give dstaddr[27:20], [19:12] and [11:4]. Byte 5 gives dstaddr[3:0] in bits 7:4, datamode in bits 3:2 and write in bit 1. Bytes 6 to 9 give data[31:0] most significant byte first, and bytes 10 to 13 give the upper word in the same order. The output word is write at bit 0, datamode at [2:1], ctrl at [6:3], 0 at bit 7, dstaddr at [39:8], data at [71:40] and the upper word at [103:72].
- R3: The word for a completed transaction appears, with a one-cycle strobe, in the cycle after the edge that samples its byte 13.
- R4: A word with write=1 goes to the write output. A word with write=0 and the read flag set goes to the read-request output. A word with write=0 and the read flag clear goes to the read-response output.
- R5: With the burst flag set and frame still high after byte 13, the next byte is byte 6 of a new transaction. That transaction reuses the previous header, and its destination address is the previous one plus 8. This repeats for every further group of eight bytes.
- R6: With the burst flag clear and frame still high after byte 13, further bytes are ignored until frame falls: no strobe and no error.
- R7: Frame falling before byte 13 of a transaction has been sampled discards that transaction with no strobe and sets the error output. The error output stays set until reset.
- R8: Frame falling directly after a completed transaction, including one inside a burst, is a clean end and does not set the error output.
- R9: Each wait output equals its almost-full input as sampled on the previous clock edge.
- R10: During and just after reset, all strobes, both wait outputs and the error output are low.
- R11: At most one output strobe is high in any cycle, and no strobe is high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, one byte per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | Frame signal from the remote transmitter |
| byte_i | input | 8 | Link byte |
| wr_afull_i | input | 1 | Write queue almost full |
| rd_afull_i | input | 1 | Read-request queue almost full |
| wr_pkt_o | output | 104 | Write transaction word |
| wr_vld_o | output | 1 | Write word strobe |
| rd_pkt_o | output | 104 | Read-request transaction word |
| rd_vld_o | output | 1 | Read-request word strobe |
| rr_pkt_o | output | 104 | Read-response transaction word |
| rr_vld_o | output | 1 | Read-response word strobe |
| wr_wait_o | output | 1 | Push-back to the transmitter for writes |
| rd_wait_o | output | 1 | Push-back to the transmitter for reads |
| err_o | output | 1 | Sticky truncated-frame error |

## Verification
The bench targets bursts first: a design that does not reload the byte index at byte 6, or does not add 8 to the address, sends later beats with a shifted payload or a repeated address. It holds frame high after a non-burst transaction, where a careless design would parse garbage as a second transaction. It cuts frames at byte 3, at byte 12 and in the middle of a second burst beat, where a design could emit a partial word or miss the error. It then ends a frame cleanly right after byte 13, where an overly eager abort check would raise a false error. All three routing outcomes are exercised. The frame gap between transactions is a single cycle, which exposes a design that misses the rise or starts a transaction one byte late.

// File: rtl/link_rx_pkg.sv
package link_rx_pkg;

  localparam int PKT_W = 104;

  typedef logic [PKT_W-1:0] pkt_t;

  typedef enum logic [1:0] {
    CH_WR = 2'd0,
    CH_RD = 2'd1,
    CH_RR = 2'd2
  } chan_e;

  // Assemble the parallel transaction word from decoded fields.
  function automatic pkt_t pack_pkt(
    input logic        wr,
    input logic [1:0]  dmode,
    input logic [3:0]  ctrl,
    input logic [31:0] dst,
    input logic [31:0] data,
    input logic [31:0] upper
  );
    return {upper, data, dst, 1'b0, ctrl, dmode, wr};
  endfunction

  // Steering decision for a finished transaction.
  function automatic chan_e pick_chan(input logic wr, input logic rd);
    if (wr)      return CH_WR;
    else if (rd) return CH_RD;
    else         return CH_RR;
  endfunction

  // Destination of the next transaction inside a burst.
  function automatic logic [31:0] next_addr(input logic [31:0] dst, input int unsigned step);
    return dst + 32'(step);
  endfunction

endpackage

// File: rtl/link_rx_framer.sv
module link_rx_framer #(
  parameter int PKT_BYTES = 14,
  parameter int HDR_BYTES = 6,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_i,
  input  logic             burst_i,
  output logic             start_ev,
  output logic             cap_ev,
  output logic             last_ev,
  output logic             abort_ev,
  output logic [IDX_W-1:0] idx_o,
  output logic             err_o
);

  localparam int LAST_IDX = PKT_BYTES - 1;

  logic             prev_q;
  logic             act_q;
  logic             part_q;
  logic             drop_q;
  logic             err_q;
  logic [IDX_W-1:0] idx_q;

  assign start_ev = frame_i & ~prev_q;
  assign cap_ev   = frame_i & prev_q & act_q & ~drop_q;
  assign last_ev  = cap_ev & (idx_q == IDX_W'(LAST_IDX));
  assign abort_ev = ~frame_i & act_q & part_q;
  assign idx_o    = idx_q;
  assign err_o    = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      act_q  <= 1'b0;
      part_q <= 1'b0;
      drop_q <= 1'b0;
      err_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      prev_q <= frame_i;
      if (abort_ev) err_q <= 1'b1;
      if (start_ev) begin
        act_q  <= 1'b1;
        part_q <= 1'b1;
        drop_q <= 1'b0;
        idx_q  <= IDX_W'(1);
      end else if (!frame_i) begin
        act_q  <= 1'b0;
        part_q <= 1'b0;
        drop_q <= 1'b0;
        idx_q  <= '0;
      end else if (last_ev) begin
        part_q <= 1'b0;
        idx_q  <= IDX_W'(HDR_BYTES);
        drop_q <= ~burst_i;
      end else if (cap_ev) begin
        part_q <= 1'b1;
        idx_q  <= idx_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/link_rx_capture.sv
module link_rx_capture
  import link_rx_pkg::*;
#(
  parameter int PKT_BYTES = 14,
  parameter int HDR_BYTES = 6,
  parameter int IDX_W     = 4,
  parameter int ADDR_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       byte_i,
  input  logic             start_ev,
  input  logic             cap_ev,
  input  logic             last_ev,
  input  logic [IDX_W-1:0] idx_i,
  output logic             rd_o,
  output logic             burst_o,
  output pkt_t             pkt_o
);

  localparam int LAST_IDX = PKT_BYTES - 1;
  localparam int PAY_W    = (PKT_BYTES - HDR_BYTES) * 8;

  logic             rd_q;
  logic             burst_q;
  logic [3:0]       ctrl_q;
  logic [31:0]      dst_q;
  logic [1:0]       dmode_q;
  logic             wr_q;
  logic [PAY_W-1:0] pay_q;
  logic [2:0]       lane;

  // Payload lane counted from the last byte: byte 13 is lane 0.
  assign lane = 3'(LAST_IDX - int'(idx_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      burst_q <= 1'b0;
      ctrl_q  <= '0;
      dst_q   <= '0;
      dmode_q <= '0;
      wr_q    <= 1'b0;
      pay_q   <= '0;
    end else begin
      if (start_ev) begin
        rd_q    <= byte_i[7];
        burst_q <= byte_i[2];
      end
      if (cap_ev) begin
        case (idx_i)
          IDX_W'(1): begin
            ctrl_q        <= byte_i[7:4];
            dst_q[31:28]  <= byte_i[3:0];
          end
          IDX_W'(2): dst_q[27:20] <= byte_i;
          IDX_W'(3): dst_q[19:12] <= byte_i;
          IDX_W'(4): dst_q[11:4]  <= byte_i;
          IDX_W'(5): begin
            dst_q[3:0] <= byte_i[7:4];
            dmode_q    <= byte_i[3:2];
            wr_q       <= byte_i[1];
          end
          default: begin
            if (idx_i >= IDX_W'(HDR_BYTES)) pay_q[{lane, 3'b000} +: 8] <= byte_i;
          end
        endcase
      end
      if (last_ev && burst_q) dst_q <= next_addr(dst_q, ADDR_STEP);
    end
  end

  assign rd_o    = rd_q;
  assign burst_o = burst_q;
  // Byte 13 is taken straight from the input on the completing edge.
  assign pkt_o   = pack_pkt(wr_q, dmode_q, ctrl_q, dst_q,
                            pay_q[PAY_W-1 -: 32], {pay_q[31:8], byte_i});

endmodule

// File: rtl/link_rx_steer.sv
module link_rx_steer
  import link_rx_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      last_ev,
  input  logic                      rd_i,
  input  pkt_t                      pkt_i,
  output logic [NCH-1:0]            vld_o,
  output logic [NCH-1:0][PKT_W-1:0] pkt_o
);

  chan_e dest;
  assign dest = pick_chan(pkt_i[0], rd_i);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    logic vld_q;
    pkt_t pkt_q;

    assign hit = last_ev && (dest == chan_e'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        pkt_q <= '0;
      end else begin
        vld_q <= hit;
        if (hit) pkt_q <= pkt_i;
      end
    end

    assign vld_o[c] = vld_q;
    assign pkt_o[c] = pkt_q;
  end

endmodule

// File: rtl/link_rx_wait.sv
module link_rx_wait #(
  parameter int NW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NW-1:0] afull_i,
  output logic [NW-1:0] wait_o
);

  for (genvar w = 0; w < NW; w++) begin : g_w
    logic wait_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wait_q <= 1'b0;
      else        wait_q <= afull_i[w];
    end
    assign wait_o[w] = wait_q;
  end

endmodule

// File: rtl/link_rx.sv
module link_rx
  import link_rx_pkg::*;
#(
  parameter int PKT_BYTES = 14,
  parameter int HDR_BYTES = 6,
  parameter int ADDR_STEP = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_i,
  input  logic [7:0]   byte_i,
  input  logic         wr_afull_i,
  input  logic         rd_afull_i,
  output logic [103:0] wr_pkt_o,
  output logic         wr_vld_o,
  output logic [103:0] rd_pkt_o,
  output logic         rd_vld_o,
  output logic [103:0] rr_pkt_o,
  output logic         rr_vld_o,
  output logic         wr_wait_o,
  output logic         rd_wait_o,
  output logic         err_o
);

  localparam int IDX_W = $clog2(PKT_BYTES);
  localparam int NCH   = 3;

  logic             start_ev;
  logic             cap_ev;
  logic             last_ev;
  logic             abort_ev;
  logic [IDX_W-1:0] idx;
  logic             burst;
  logic             rd_flag;
  pkt_t             pkt_asm;
  logic [NCH-1:0]            ch_vld;
  logic [NCH-1:0][PKT_W-1:0] ch_pkt;
  logic [1:0]                waits;

  link_rx_framer #(
    .PKT_BYTES(PKT_BYTES), .HDR_BYTES(HDR_BYTES), .IDX_W(IDX_W)
  ) u_framer (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .burst_i(burst),
    .start_ev(start_ev), .cap_ev(cap_ev), .last_ev(last_ev),
    .abort_ev(abort_ev), .idx_o(idx), .err_o(err_o)
  );

  link_rx_capture #(
    .PKT_BYTES(PKT_BYTES), .HDR_BYTES(HDR_BYTES), .IDX_W(IDX_W), .ADDR_STEP(ADDR_STEP)
  ) u_capture (
    .clk(clk), .rst_n(rst_n), .byte_i(byte_i), .start_ev(start_ev),
    .cap_ev(cap_ev), .last_ev(last_ev), .idx_i(idx),
    .rd_o(rd_flag), .burst_o(burst), .pkt_o(pkt_asm)
  );

  link_rx_steer #(.NCH(NCH)) u_steer (
    .clk(clk), .rst_n(rst_n), .last_ev(last_ev), .rd_i(rd_flag),
    .pkt_i(pkt_asm), .vld_o(ch_vld), .pkt_o(ch_pkt)
  );

  link_rx_wait #(.NW(2)) u_wait (
    .clk(clk), .rst_n(rst_n), .afull_i({rd_afull_i, wr_afull_i}), .wait_o(waits)
  );

  assign wr_vld_o  = ch_vld[CH_WR];
  assign rd_vld_o  = ch_vld[CH_RD];
  assign rr_vld_o  = ch_vld[CH_RR];
  assign wr_pkt_o  = ch_pkt[CH_WR];
  assign rd_pkt_o  = ch_pkt[CH_RD];
  assign rr_pkt_o  = ch_pkt[CH_RR];
  assign wr_wait_o = waits[0];
  assign rd_wait_o = waits[1];

endmodule

// File: rtl/link_rx_chk.sv
module link_rx_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_vld_o,
  input logic             rd_vld_o,
  input logic             rr_vld_o,
  input logic             wr_wait_o,
  input logic             rd_wait_o,
  input logic             wr_afull_i,
  input logic             rd_afull_i,
  input logic             err_o,
  input logic             start_ev,
  input logic             last_ev,
  input logic             abort_ev,
  input logic [IDX_W-1:0] idx
);

  logic any_vld;
  assign any_vld = wr_vld_o | rd_vld_o | rr_vld_o;

  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_vld_o, rd_vld_o, rr_vld_o}));

  // R11
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_vld |=> !any_vld);

  // R3
  strobe_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_ev |=> any_vld);

  // R3
  strobe_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_vld |-> $past(last_ev));

  // R7
  abort_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> err_o);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  // R7
  abort_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> !any_vld);

  // R1
  start_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (idx == IDX_W'(1)));

  // R9
  wr_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (wr_wait_o == $past(wr_afull_i)));

  // R9
  rd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rd_wait_o == $past(rd_afull_i)));

endmodule

bind link_rx link_rx_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .wr_vld_o(wr_vld_o), .rd_vld_o(rd_vld_o), .rr_vld_o(rr_vld_o),
  .wr_wait_o(wr_wait_o), .rd_wait_o(rd_wait_o),
  .wr_afull_i(wr_afull_i), .rd_afull_i(rd_afull_i),
  .err_o(err_o), .start_ev(start_ev), .last_ev(last_ev),
  .abort_ev(abort_ev), .idx(idx)
);

// File: tb/link_rx_bench.sv
`timescale 1ns/1ps
module link_rx_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         frame = 1'b0;
  logic [7:0]   byte_v = 8'h00;
  logic         wr_afull = 1'b0;
  logic         rd_afull = 1'b0;
  logic [103:0] wr_pkt, rd_pkt, rr_pkt;
  logic         wr_vld, rd_vld, rr_vld, wr_wait, rd_wait, err;

  int    compared = 0;
  int    mismatched = 0;
  bit    done = 1'b0;
  string phase = "R10 reset";

  always #2 clk = ~clk;

  link_rx u_link_rx (
    .clk(clk), .rst_n(rst_n), .frame_i(frame), .byte_i(byte_v),
    .wr_afull_i(wr_afull), .rd_afull_i(rd_afull),
    .wr_pkt_o(wr_pkt), .wr_vld_o(wr_vld), .rd_pkt_o(rd_pkt), .rd_vld_o(rd_vld),
    .rr_pkt_o(rr_pkt), .rr_vld_o(rr_vld), .wr_wait_o(wr_wait), .rd_wait_o(rd_wait),
    .err_o(err)
  );

  // ---------------- reference model: byte queue, parsed at 14 bytes ----------------
  logic [7:0]   mq[$];
  bit           m_prev, m_in, m_fresh, m_drop;
  logic [2:0]   e_vld;
  logic [103:0] e_pkt[3];
  logic [1:0]   e_wait;
  logic         e_err;

  function automatic logic [31:0] q_dst();
    return {mq[1][3:0], mq[2], mq[3], mq[4], mq[5][7:4]};
  endfunction

  task automatic model_emit();
    logic [31:0] d = q_dst();
    logic [103:0] w;
    int ch;
    w = {mq[10], mq[11], mq[12], mq[13], mq[6], mq[7], mq[8], mq[9], d,
         1'b0, mq[1][7:4], mq[5][3:2], mq[5][1]};
    ch = mq[5][1] ? 0 : (mq[0][7] ? 1 : 2);
    e_vld[ch] = 1'b1;
    e_pkt[ch] = w;
    m_fresh = 1'b1;
    if (mq[0][2]) begin
      d = d + 32'd8;
      mq[1] = {mq[1][7:4], d[31:28]};
      mq[2] = d[27:20];
      mq[3] = d[19:12];
      mq[4] = d[11:4];
      mq[5] = {d[3:0], mq[5][3:0]};
      mq = mq[0:5];
    end else begin
      m_drop = 1'b1;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq = {}; m_prev = 0; m_in = 0; m_fresh = 0; m_drop = 0;
      e_vld = '0; e_wait = '0; e_err = 0;
      for (int i = 0; i < 3; i++) e_pkt[i] = '0;
    end else begin
      e_vld  = '0;
      e_wait = {rd_afull, wr_afull};
      if (frame && !m_prev) begin
        mq = {byte_v}; m_in = 1; m_fresh = 0; m_drop = 0;
      end else if (!frame) begin
        if (m_in && !m_fresh) e_err = 1'b1;
        m_in = 0; m_drop = 0; mq = {};
      end else if (m_in && !m_drop) begin
        mq.push_back(byte_v);
        m_fresh = 0;
        if (mq.size() == 14) model_emit();
      end
      m_prev = frame;
    end
  end

  // ---------------- comparison away from the active edge ----------------
  task automatic chk(string tag, string what, logic [103:0] got, logic [103:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s [%s] %s got=%h exp=%h", tag, phase, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("R3/R4", "wr_vld", 104'(wr_vld), 104'(e_vld[0]));
      chk("R3/R4", "rd_vld", 104'(rd_vld), 104'(e_vld[1]));
      chk("R3/R4", "rr_vld", 104'(rr_vld), 104'(e_vld[2]));
      if (e_vld[0]) chk("R2", "wr_pkt", wr_pkt, e_pkt[0]);
      if (e_vld[1]) chk("R2", "rd_pkt", rd_pkt, e_pkt[1]);
      if (e_vld[2]) chk("R2", "rr_pkt", rr_pkt, e_pkt[2]);
      chk("R9", "wr_wait", 104'(wr_wait), 104'(e_wait[0]));
      chk("R9", "rd_wait", 104'(rd_wait), 104'(e_wait[1]));
      chk("R7", "err", 104'(err), 104'(e_err));
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(bit f, logic [7:0] b);
    @(negedge clk);
    frame  = f;
    byte_v = b;
  endtask

  // beats: payload groups; extra: bytes after the last beat; cut >= 0 truncates.
  task automatic send_txn(bit rd, bit bst, logic [3:0] ctrl, logic [31:0] dst,
                          logic [1:0] dm, bit wr, logic [7:0] seed,
                          int beats, int extra, int cut, int gap);
    logic [7:0] s[$];
    s = {{rd, 4'b0000, bst, 2'b00}, {ctrl, dst[31:28]}, dst[27:20], dst[19:12],
         dst[11:4], {dst[3:0], dm, wr, 1'b1}};
    for (int k = 0; k < beats * 8 + extra; k++) s.push_back(seed + 8'(k * 37));
    if (cut >= 0) s = s[0:cut-1];
    foreach (s[i]) drive(1'b1, s[i]);
    for (int g = 0; g < gap; g++) drive(1'b0, 8'hA5);
  endtask

  initial begin
    int n = 0;
    @(negedge clk);
    forever begin
      @(negedge clk);
      n++;
      wr_afull = (n % 7) < 2;
      rd_afull = (n % 5) == 3;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    phase = "R1 R2 R4 single write";
    send_txn(0, 0, 4'h5, 32'h8080_0010, 2'b10, 1, 8'h11, 1, 0, -1, 3);
    phase = "R4 read request";
    send_txn(1, 0, 4'h3, 32'h1234_5678, 2'b11, 0, 8'h40, 1, 0, -1, 1);
    phase = "R4 read response, one-cycle gap";
    send_txn(0, 0, 4'hA, 32'hFEDC_BA98, 2'b01, 0, 8'h9C, 1, 0, -1, 1);
    phase = "R5 R8 write burst of three";
    send_txn(0, 1, 4'h1, 32'h0000_0FF8, 2'b11, 1, 8'h22, 3, 0, -1, 2);
    phase = "R5 read burst of two";
    send_txn(1, 1, 4'h7, 32'hFFFF_FFF8, 2'b10, 0, 8'h5B, 2, 0, -1, 2);
    phase = "R6 held frame without burst";
    send_txn(0, 0, 4'h2, 32'hAAAA_0000, 2'b00, 1, 8'h77, 1, 11, -1, 2);
    phase = "R11 back to back frames";
    send_txn(0, 0, 4'h4, 32'h0101_0101, 2'b10, 1, 8'h01, 1, 0, -1, 1);
    send_txn(0, 0, 4'h6, 32'h0202_0202, 2'b10, 0, 8'h02, 1, 0, -1, 1);
    phase = "R7 abort at byte 3";
    send_txn(0, 0, 4'h9, 32'h3333_3333, 2'b10, 1, 8'h33, 1, 0, 3, 2);
    phase = "R7 abort before byte 13";
    send_txn(1, 0, 4'h9, 32'h4444_4444, 2'b10, 0, 8'h44, 1, 0, 13, 2);
    phase = "R7 abort inside second burst beat";
    send_txn(0, 1, 4'hC, 32'h5555_5550, 2'b11, 1, 8'h55, 2, 0, 18, 2);
    phase = "R2 traffic after error";
    send_txn(0, 0, 4'hF, 32'hC0DE_0008, 2'b11, 0, 8'hE1, 1, 0, -1, 4);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog [%s] got=hung exp=finished", phase);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule